// File: doc/BRIEF.md
# Memory Command Readiness Gate

This block decides when a controller may start sending read and write commands to a synchronous memory whose input clock is aligned by an on-die delay-locked loop. Commands are allowed only when two separate conditions both hold. The first is a lock condition: a set number of stable input clock cycles has elapsed since the loop was last enabled. This condition re-arms whenever the loop-enable level drops or the input clock stalls. The second is a one-time start-up wait: the input clock must have run for a set amount of time after reset. Once this wait has been met, it stays met.

All logic runs on a free-running timebase clock. The timebase must be at least twice as fast as the input clock, and the input clock is sampled as data. A gap counter on the timebase restarts at every rising edge of the input clock. When the counter reaches its threshold, the input clock is declared stopped, and that resets the lock count. The start-up timer counts timebase ticks only while the input clock is running. The lock count and the start-up wait can therefore progress at the same time.

Top module: `dll_lock_gate`

## Requirements
- R1: While reset is asserted, and directly after it is released, `cmd_ok`, `locked` and `init_done` are all 0.
- R2: With `dll_en` high and the input clock running, `locked` rises after `LOCK_CYCLES` rising edges of the input clock have been counted. It does not rise earlier.
- R3: When `dll_en` goes low, `locked` is 0 from the next timebase cycle onward. A later rise of `dll_en` requires a full new count of `LOCK_CYCLES` edges.
- R4: If no input clock rising edge arrives for `STOP_TICKS` timebase ticks, the clock is treated as stopped. `locked` then clears, and the count restarts from zero once the clock returns.
- R5: A pause of the input clock that keeps the interval between rising edges below `STOP_TICKS` ticks leaves `locked` at 1.
- R6: `init_done` rises after `INIT_TICKS` timebase ticks during which the input clock was running. Ticks during which the clock is stopped do not count.
- R7: Once `init_done` is 1, it stays 1 through `dll_en` drops and clock stalls. Only reset clears it.
- R8: `cmd_ok` is 1 exactly when `locked` and `init_done` are both 1.
- R9: After reset, the input clock counts as stopped until its first rising edge. Neither the lock count nor the start-up timer advances before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running timebase clock, at least twice the input clock rate |
| rst_n | input | 1 | Active-low reset, synchronous to `ref_clk` (power-up) |
| kclk_in | input | 1 | Memory input clock, sampled as data |
| dll_en | input | 1 | Loop-enable level, synchronous to `ref_clk` |
| cmd_ok | output | 1 | Read and write commands may be issued |
| locked | output | 1 | Lock count met since the last disable or clock stall |
| init_done | output | 1 | One-time start-up wait met |

## Verification
If the gap counter holds a wrong value, `locked` would drop on a short clock pause, or would survive a real stall for longer than `STOP_TICKS` ticks. Either effect is visible at the port within a few input clock periods. If the start-up timer advanced while the clock was stopped, `init_done` would rise before `INIT_TICKS` running ticks had elapsed. A lock counter that fails to re-arm would show `locked` high too soon after `dll_en` returns. Each of these faults appears within one lock window, at the latest.

// File: rtl/dll_gate_pkg.sv
package dll_gate_pkg;

  // Bits needed to hold values 0..limit inclusive.
  function automatic int unsigned cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Next value of a counter that saturates at limit.
  function automatic int unsigned sat_step(int unsigned cur, int unsigned limit, bit adv);
    if (!adv || cur >= limit) return cur;
    return cur + 1;
  endfunction

endpackage

// File: rtl/kclk_edge_sync.sv
module kclk_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic kclk_in,
  output logic k_rise
);
  localparam int unsigned TOP = SYNC_STAGES;

  logic [TOP:0] shift_q;

  always_ff @(posedge ref_clk) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[TOP-1:0], kclk_in};
  end

  assign k_rise = shift_q[TOP-1] & ~shift_q[TOP];

  // R9: a rise is a single-cycle event
  p_rise_single_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    k_rise |=> !k_rise);
endmodule

// File: rtl/stall_watch.sv
module stall_watch
  import dll_gate_pkg::*;
#(
  parameter int unsigned STOP_TICKS = 30
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic k_rise,
  output logic k_stopped
);
  localparam int unsigned W = cnt_width(STOP_TICKS);
  localparam logic [W-1:0] LIMIT = W'(STOP_TICKS);

  logic [W-1:0] gap_q;

  always_ff @(posedge ref_clk) begin
    if (!rst_n)      gap_q <= LIMIT;   // no clock seen yet
    else if (k_rise) gap_q <= '0;
    else             gap_q <= W'(sat_step(int'(gap_q), STOP_TICKS, 1'b1));
  end

  assign k_stopped = (gap_q == LIMIT);

  p_gap_bound_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    gap_q <= LIMIT);
  p_rise_clears_stop_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    k_rise |=> !k_stopped);
endmodule

// File: rtl/lock_count.sv
module lock_count
  import dll_gate_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 2048
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic dll_en,
  input  logic k_rise,
  input  logic k_stopped,
  output logic locked
);
  localparam int unsigned W = cnt_width(LOCK_CYCLES);
  localparam logic [W-1:0] LIMIT = W'(LOCK_CYCLES);

  logic [W-1:0] cnt_q;
  logic         run;

  assign run = dll_en & ~k_stopped;

  always_ff @(posedge ref_clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else                cnt_q <= W'(sat_step(int'(cnt_q), LOCK_CYCLES, k_rise));
  end

  assign locked = (cnt_q == LIMIT);

  p_no_overflow_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  p_lock_on_edge_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(locked) |-> $past(k_rise && dll_en));
  p_disable_drops_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !dll_en |=> !locked);
  p_stall_drops_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    k_stopped |=> !locked);
endmodule

// File: rtl/init_timer.sv
module init_timer
  import dll_gate_pkg::*;
#(
  parameter int unsigned INIT_TICKS = 20000
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic k_stopped,
  output logic init_done
);
  localparam int unsigned W = cnt_width(INIT_TICKS);
  localparam logic [W-1:0] LIMIT = W'(INIT_TICKS);

  logic [W-1:0] tick_q;

  always_ff @(posedge ref_clk) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= W'(sat_step(int'(tick_q), INIT_TICKS, !k_stopped));
  end

  assign init_done = (tick_q == LIMIT);

  p_sticky_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_runs_only_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(!k_stopped));
endmodule

// File: rtl/dll_lock_gate.sv
module dll_lock_gate #(
  parameter int unsigned LOCK_CYCLES = 2048,
  parameter int unsigned STOP_TICKS  = 30,
  parameter int unsigned INIT_TICKS  = 20000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic kclk_in,
  input  logic dll_en,
  output logic cmd_ok,
  output logic locked,
  output logic init_done
);
  logic k_rise;
  logic k_stopped;

  kclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .ref_clk(ref_clk), .rst_n(rst_n), .kclk_in(kclk_in), .k_rise(k_rise));

  stall_watch #(.STOP_TICKS(STOP_TICKS)) u_stall (
    .ref_clk(ref_clk), .rst_n(rst_n), .k_rise(k_rise), .k_stopped(k_stopped));

  lock_count #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .ref_clk(ref_clk), .rst_n(rst_n), .dll_en(dll_en), .k_rise(k_rise),
    .k_stopped(k_stopped), .locked(locked));

  init_timer #(.INIT_TICKS(INIT_TICKS)) u_init (
    .ref_clk(ref_clk), .rst_n(rst_n), .k_stopped(k_stopped), .init_done(init_done));

  assign cmd_ok = locked & init_done;

  p_gate_needs_init_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !init_done |-> !cmd_ok);
  p_reset_quiet_r1: assert property (@(posedge ref_clk)
    !rst_n |=> !locked && !init_done);
endmodule

// File: tb/dll_lock_gate_test.sv
module dll_lock_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_N     = 16;
  localparam int STOP_N     = 8;
  localparam int INIT_N     = 160;
  localparam int KPER       = 4;     // timebase ticks per input clock period

  // vector fields: {dll_en, clock_running, periods_to_wait, exp_locked, exp_init}
  typedef struct packed {
    logic       en;
    logic       run;
    logic [7:0] periods;
    logic       e_lock;
    logic       e_init;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'd10, 1'b0, 1'b0},  // R3: no enable, no lock
    '{1'b1, 1'b1, 8'd14, 1'b0, 1'b0},  // R2: before full count
    '{1'b1, 1'b1, 8'd4,  1'b1, 1'b0},  // R2: count met; R8 init missing
    '{1'b1, 1'b1, 8'd10, 1'b1, 1'b0},  // R6: init not yet
    '{1'b1, 1'b1, 8'd6,  1'b1, 1'b1},  // R6/R8: both met
    '{1'b0, 1'b1, 8'd1,  1'b0, 1'b1},  // R3/R7: disable drops lock only
    '{1'b1, 1'b1, 8'd10, 1'b0, 1'b1},  // R3: relock needs full count
    '{1'b1, 1'b1, 8'd8,  1'b1, 1'b1},  // R3: relocked
    '{1'b1, 1'b0, 8'd4,  1'b0, 1'b1},  // R4/R7: stall drops lock only
    '{1'b1, 1'b1, 8'd14, 1'b0, 1'b1},  // R4: count restarted
    '{1'b1, 1'b1, 8'd6,  1'b1, 1'b1}   // R4: relocked after stall
  };

  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic kclk_in = 1'b0;
  logic dll_en  = 1'b0;
  logic kclk_run = 1'b0;
  logic ph = 1'b0;
  logic cmd_ok, locked, init_done;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dll_lock_gate #(.LOCK_CYCLES(LOCK_N), .STOP_TICKS(STOP_N), .INIT_TICKS(INIT_N)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .kclk_in(kclk_in), .dll_en(dll_en),
    .cmd_ok(cmd_ok), .locked(locked), .init_done(init_done));

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  // input clock: toggles every second timebase tick while running
  always @(negedge ref_clk) begin
    if (kclk_run) begin
      ph <= ~ph;
      if (ph) kclk_in <= ~kclk_in;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic check_all(input string req, input logic el, input logic ei);
    check(req, locked, el, "locked");
    check(req, init_done, ei, "init_done");
    check("R8", cmd_ok, el & ei, "cmd_ok");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    ticks(3);
    check_all("R1", 1'b0, 1'b0);
    kclk_run = 1'b1;
    ticks(1);
    rst_n = 1'b1;
    ticks(1);
    check_all("R1", 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      dll_en   = VECS[v].en;
      kclk_run = VECS[v].run;
      ticks(KPER * int'(VECS[v].periods));
      check_all($sformatf("R2-table v%0d", v), VECS[v].e_lock, VECS[v].e_init);
    end

    // R5: short pause keeps lock
    begin
      logic held;
      held = 1'b1;
      kclk_run = 1'b0;
      for (int i = 0; i < 3; i++) begin
        @(negedge ref_clk);
        held &= locked;
      end
      kclk_run = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge ref_clk);
        held &= locked;
      end
      check("R5", held, 1'b1, "locked held through short pause");
    end

    // R1/R7: only reset clears init_done
    rst_n = 1'b0;
    ticks(2);
    check_all("R1", 1'b0, 1'b0);
    check("R7", init_done, 1'b0, "init_done after reset");

    // R9/R6: no clock after reset, nothing advances
    kclk_run = 1'b0;
    dll_en = 1'b1;
    ticks(1);
    rst_n = 1'b1;
    ticks(30 * KPER);
    check("R9", locked, 1'b0, "locked without clock");
    check("R6", init_done, 1'b0, "init_done without clock");
    kclk_run = 1'b1;
    ticks(30 * KPER);
    check("R6", init_done, 1'b0, "init_done stall ticks not counted");
    check("R9", locked, 1'b1, "locked after clock start");
    ticks(14 * KPER);
    check("R6", init_done, 1'b1, "init_done after running ticks");
    check("R8", cmd_ok, 1'b1, "cmd_ok both met");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule